// File: doc/BRIEF.md
# Load/Store Address Generator with Base Update

This block turns a single-register load or store instruction word into the controls a memory port needs. It takes the base register value, the value of the offset register, and an incoming carry flag. From these it forms the offset, which is either a 12-bit immediate or a shifted register value. It then adds or subtracts the offset from the base and decides whether the transfer uses the changed address or the original base. It also reports whether the base register must be updated and with which value. All results are registered, so they appear one clock after the instruction is presented.

On the cycle after a transfer is issued, the memory returns read data. The block uses the registered address to give the byte enables for that transfer, and it zero-extends the selected byte lane when the load is a byte load. Condition evaluation, register-file storage, memory, and alignment handling beyond byte and word selection stay outside the block.

Top module: `ldst_agu`

## Requirements
- R1: While reset is low and after it is released with no instruction issued, every output is zero.
- R2: Results appear one clock after `valid_i` is sampled high. A cycle sampled with `valid_i` low gives `xfer_vld_o`, `wb_en_o` and `xfer_be_o` all zero on the next cycle.
- R3: When instruction bit 24 is 1 (pre-index), the transfer address is the base combined with the offset.
- R4: When instruction bit 24 is 0 (post-index), the transfer address is the unmodified base. The base update is always requested, carrying the base combined with the offset, whatever bit 21 holds.
- R5: Instruction bit 23 set to 1 adds the offset to the base. Set to 0, it subtracts the offset from the base.
- R6: For pre-indexed transfers, bit 21 set to 1 requests a base update equal to the transfer address. Bit 21 set to 0 requests none.
- R7: When instruction bit 25 is 0, the offset is bits 11:0 zero-extended.
- R8: When bit 25 is 1, the offset is the offset register value shifted by the amount in bits 11:7, with the shift kind taken from bits 6:5: 00 shifts left, 01 shifts right logically, 10 shifts right arithmetically, and 11 rotates right.
- R9: A shift amount of zero has a fixed meaning for each kind. A left shift leaves the value unchanged. A logical right shift gives zero. An arithmetic right shift gives 32 copies of the sign bit. A rotate shifts right one place through `carry_i`, with the carry entering bit 31.
- R10: Bit 22 drives `xfer_byte_o` (1 = byte) and bit 20 drives `xfer_load_o` (1 = load). Bits 19:16 appear on `wb_reg_o` and bits 15:12 appear on `data_reg_o`.
- R11: A word transfer drives byte enables 4'b1111. A byte transfer drives a one-hot enable with bit n set, where n is address bits 1:0.
- R12: `ld_data_o` returns `mem_rdata_i` unchanged for word transfers. For byte transfers it returns the byte lane chosen by address bits 1:0, zero-extended.
- R13: Word 0xE56DA004 gives a byte store at base minus 4 with a base update. Word 0xE59D8000 gives a word load at the base with no update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Instruction word is valid this cycle |
| instr_i | input | 32 | Load/store instruction word |
| base_i | input | 32 | Base register value |
| rm_val_i | input | 32 | Offset register value |
| carry_i | input | 1 | Carry flag used by the zero-amount rotate |
| mem_rdata_i | input | 32 | Read data returned for the registered transfer |
| xfer_vld_o | output | 1 | Transfer request valid |
| xfer_addr_o | output | 32 | Transfer byte address |
| xfer_byte_o | output | 1 | 1 = byte transfer, 0 = word transfer |
| xfer_load_o | output | 1 | 1 = load, 0 = store |
| xfer_be_o | output | 4 | Byte-lane enables |
| wb_en_o | output | 1 | Base register update request |
| wb_reg_o | output | 4 | Index of the base register |
| wb_data_o | output | 32 | New base value |
| data_reg_o | output | 4 | Index of the data register |
| ld_data_o | output | 32 | Formatted load data |

## Verification
A transfer and a base update can occur in the same cycle, and they relate in two different ways. In a pre-indexed update, both outputs carry the same combined value. In a post-indexed update, the address is the old base while the update carries the new value. The random stimulus sets the index, direction and update bits in every combination, so both cases occur together many times. Directed words cover the two reference encodings, a post-indexed byte load, and each zero-amount shift. The reference function judges the address, the update value and the update enable together for each cycle.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

    localparam int unsigned XLEN = 32;
    localparam int unsigned RIDX_W = 4;
    localparam int unsigned IMM_W = 12;

    // instruction field positions that the behaviour depends on
    localparam int unsigned POS_IMM_SEL = 25;
    localparam int unsigned POS_PRE = 24;
    localparam int unsigned POS_UP = 23;
    localparam int unsigned POS_BYTE = 22;
    localparam int unsigned POS_WBACK = 21;
    localparam int unsigned POS_LOAD = 20;

    typedef enum logic [1:0] {
        SH_LEFT = 2'b00,
        SH_RLOG = 2'b01,
        SH_RARI = 2'b10,
        SH_ROTR = 2'b11
    } shift_kind_e;

    typedef struct packed {
        logic vld;
        logic [XLEN-1:0] addr;
        logic byte_sel;
        logic load;
        logic wb_en;
        logic [XLEN-1:0] wb_data;
        logic [RIDX_W-1:0] wb_reg;
        logic [RIDX_W-1:0] data_reg;
    } xfer_t;

endpackage

// File: rtl/ldst_offset_shifter.sv
module ldst_offset_shifter
    import ldst_pkg::*;
#(
    parameter int W = 32,
    localparam int AW = $clog2(W)
) (
    input  logic [W-1:0]  rm_i,
    input  logic [AW-1:0] amt_i,
    input  shift_kind_e   kind_i,
    input  logic          cin_i,
    output logic [W-1:0]  res_o
);

    logic zero_amt;
    assign zero_amt = (amt_i == '0);

    always_comb begin
        res_o = rm_i;
        unique case (kind_i)
            SH_LEFT: res_o = rm_i << amt_i;
            SH_RLOG: res_o = zero_amt ? '0 : (rm_i >> amt_i);
            SH_RARI: res_o = zero_amt ? {W{rm_i[W-1]}}
                                      : $unsigned($signed(rm_i) >>> amt_i);
            SH_ROTR: res_o = zero_amt ? {cin_i, rm_i[W-1:1]}
                                      : ((rm_i >> amt_i) | (rm_i << (W - int'(amt_i))));
            default: res_o = rm_i;
        endcase
    end

endmodule

// File: rtl/ldst_addr_calc.sv
module ldst_addr_calc #(
    parameter int W = 32
) (
    input  logic [W-1:0] base_i,
    input  logic [W-1:0] off_i,
    input  logic         up_i,
    input  logic         pre_i,
    input  logic         wback_i,
    output logic [W-1:0] addr_o,
    output logic [W-1:0] upd_o,
    output logic         upd_en_o
);

    logic [W-1:0] moved;

    always_comb begin
        moved = up_i ? (base_i + off_i) : (base_i - off_i);
        addr_o = pre_i ? moved : base_i;
        upd_o = moved;
        upd_en_o = wback_i | ~pre_i;
    end

endmodule

// File: rtl/ldst_lane_ctrl.sv
module ldst_lane_ctrl #(
    parameter int W = 32,
    localparam int NL = W / 8,
    localparam int LW = $clog2(NL)
) (
    input  logic          vld_i,
    input  logic          byte_i,
    input  logic [LW-1:0] lane_i,
    input  logic [W-1:0]  rdata_i,
    output logic [NL-1:0] be_o,
    output logic [W-1:0]  ldata_o
);

    logic [7:0] lanes [NL];

    for (genvar g = 0; g < NL; g++) begin : g_lane
        assign lanes[g] = rdata_i[8*g +: 8];
        assign be_o[g] = vld_i & (~byte_i | (lane_i == LW'(g)));
    end

    assign ldata_o = byte_i ? {{(W-8){1'b0}}, lanes[lane_i]} : rdata_i;

endmodule

// File: rtl/ldst_agu.sv
module ldst_agu
    import ldst_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        valid_i,
    input  logic [31:0] instr_i,
    input  logic [31:0] base_i,
    input  logic [31:0] rm_val_i,
    input  logic        carry_i,
    input  logic [31:0] mem_rdata_i,
    output logic        xfer_vld_o,
    output logic [31:0] xfer_addr_o,
    output logic        xfer_byte_o,
    output logic        xfer_load_o,
    output logic [3:0]  xfer_be_o,
    output logic        wb_en_o,
    output logic [3:0]  wb_reg_o,
    output logic [31:0] wb_data_o,
    output logic [3:0]  data_reg_o,
    output logic [31:0] ld_data_o
);

    localparam int NLANE = XLEN / 8;
    localparam int LANE_W = $clog2(NLANE);
    localparam int SAMT_W = $clog2(XLEN);

    xfer_t nxt_d, cur_q;

    logic [XLEN-1:0] sh_res, off_w, addr_w, upd_w;
    logic upd_en_w;
    logic unused_bits;

    assign unused_bits = ^instr_i[31:26];

    ldst_offset_shifter #(.W(XLEN)) u_shift (
        .rm_i   (rm_val_i),
        .amt_i  (instr_i[7 +: SAMT_W]),
        .kind_i (shift_kind_e'(instr_i[6:5])),
        .cin_i  (carry_i),
        .res_o  (sh_res)
    );

    assign off_w = instr_i[POS_IMM_SEL] ? sh_res
                                        : {{(XLEN-IMM_W){1'b0}}, instr_i[IMM_W-1:0]};

    ldst_addr_calc #(.W(XLEN)) u_calc (
        .base_i   (base_i),
        .off_i    (off_w),
        .up_i     (instr_i[POS_UP]),
        .pre_i    (instr_i[POS_PRE]),
        .wback_i  (instr_i[POS_WBACK]),
        .addr_o   (addr_w),
        .upd_o    (upd_w),
        .upd_en_o (upd_en_w)
    );

    always_comb begin
        nxt_d = '0;
        if (valid_i) begin
            nxt_d.vld = 1'b1;
            nxt_d.addr = addr_w;
            nxt_d.byte_sel = instr_i[POS_BYTE];
            nxt_d.load = instr_i[POS_LOAD];
            nxt_d.wb_en = upd_en_w;
            nxt_d.wb_data = upd_w;
            nxt_d.wb_reg = instr_i[19:16];
            nxt_d.data_reg = instr_i[15:12];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else cur_q <= nxt_d;
    end

    ldst_lane_ctrl #(.W(XLEN)) u_lane (
        .vld_i   (cur_q.vld),
        .byte_i  (cur_q.byte_sel),
        .lane_i  (cur_q.addr[LANE_W-1:0]),
        .rdata_i (mem_rdata_i),
        .be_o    (xfer_be_o),
        .ldata_o (ld_data_o)
    );

    assign xfer_vld_o = cur_q.vld;
    assign xfer_addr_o = cur_q.addr;
    assign xfer_byte_o = cur_q.byte_sel;
    assign xfer_load_o = cur_q.load;
    assign wb_en_o = cur_q.wb_en;
    assign wb_reg_o = cur_q.wb_reg;
    assign wb_data_o = cur_q.wb_data;
    assign data_reg_o = cur_q.data_reg;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_vld_o |-> (!wb_en_o && xfer_be_o == '0)); // R2
    AST_POST_WB_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !instr_i[POS_PRE]) |=> (wb_en_o && xfer_addr_o == $past(base_i))); // R4
    AST_PRE_WB_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && instr_i[POS_PRE] && instr_i[POS_WBACK]) |=> (wb_en_o && wb_data_o == xfer_addr_o)); // R6
    AST_PRE_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && instr_i[POS_PRE] && !instr_i[POS_WBACK]) |=> !wb_en_o); // R6
    AST_BYTE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_vld_o && xfer_byte_o) |-> $onehot0(xfer_be_o) && xfer_be_o != '0); // R11
    AST_WORD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_vld_o && !xfer_byte_o) |-> $countones(xfer_be_o) == NLANE); // R11
    AST_BYTE_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_byte_o |-> ld_data_o[XLEN-1:8] == '0); // R12

endmodule

// File: tb/tb_ldst_agu.sv
module tb_ldst_agu;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic valid_i = 1'b0;
    logic [31:0] instr_i = '0, base_i = '0, rm_val_i = '0, mem_rdata_i = '0;
    logic carry_i = 1'b0;
    logic xfer_vld_o, xfer_byte_o, xfer_load_o, wb_en_o;
    logic [31:0] xfer_addr_o, wb_data_o, ld_data_o;
    logic [3:0] xfer_be_o, wb_reg_o, data_reg_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ldst_agu dut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .instr_i(instr_i),
        .base_i(base_i), .rm_val_i(rm_val_i), .carry_i(carry_i),
        .mem_rdata_i(mem_rdata_i), .xfer_vld_o(xfer_vld_o),
        .xfer_addr_o(xfer_addr_o), .xfer_byte_o(xfer_byte_o),
        .xfer_load_o(xfer_load_o), .xfer_be_o(xfer_be_o), .wb_en_o(wb_en_o),
        .wb_reg_o(wb_reg_o), .wb_data_o(wb_data_o), .data_reg_o(data_reg_o),
        .ld_data_o(ld_data_o)
    );

    typedef struct packed {
        logic vld;
        logic [31:0] addr;
        logic bsel;
        logic load;
        logic [3:0] be;
        logic wb_en;
        logic [31:0] wb_data;
        logic [3:0] wb_reg;
        logic [3:0] data_reg;
    } exp_t;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] shifted(input logic [31:0] v, input logic [4:0] a,
                                            input logic [1:0] k, input logic c);
        case (k)
            2'b00: return v << a;
            2'b01: return (a == 0) ? 32'h0 : v >> a;
            2'b10: return (a == 0) ? {32{v[31]}} : $unsigned($signed(v) >>> a);
            default: return (a == 0) ? {c, v[31:1]} : ((v >> a) | (v << (32 - a)));
        endcase
    endfunction

    function automatic exp_t model(input logic v, input logic [31:0] ins, input logic [31:0] b,
                                   input logic [31:0] r, input logic c);
        exp_t e;
        logic [31:0] off, nb;
        e = '0;
        if (!v) return e;
        off = ins[25] ? shifted(r, ins[11:7], ins[6:5], c) : {20'h0, ins[11:0]};
        nb = ins[23] ? b + off : b - off;
        e.vld = 1'b1;
        e.addr = ins[24] ? nb : b;
        e.bsel = ins[22];
        e.load = ins[20];
        e.be = ins[22] ? (4'b0001 << e.addr[1:0]) : 4'b1111;
        e.wb_en = ins[21] | ~ins[24];
        e.wb_data = nb;
        e.wb_reg = ins[19:16];
        e.data_reg = ins[15:12];
        return e;
    endfunction

    task automatic issue(input logic v, input logic [31:0] ins, input logic [31:0] b,
                         input logic [31:0] r, input logic c, input string tag);
        exp_t e;
        logic [31:0] rd, exp_ld;
        valid_i = v; instr_i = ins; base_i = b; rm_val_i = r; carry_i = c;
        e = model(v, ins, b, r, c);
        @(posedge clk);
        @(negedge clk);
        valid_i = 1'b0;
        rd = $urandom;
        mem_rdata_i = rd;
        #0.5;
        exp_ld = e.bsel ? {24'h0, rd[8*e.addr[1:0] +: 8]} : rd;
        chk({tag, " R2 vld"}, {31'h0, xfer_vld_o}, {31'h0, e.vld});
        chk({tag, " R3/R4/R5 addr"}, xfer_addr_o, e.addr);
        chk({tag, " R10 byte"}, {31'h0, xfer_byte_o}, {31'h0, e.bsel});
        chk({tag, " R10 load"}, {31'h0, xfer_load_o}, {31'h0, e.load});
        chk({tag, " R11 be"}, {28'h0, xfer_be_o}, {28'h0, e.be});
        chk({tag, " R4/R6 wb_en"}, {31'h0, wb_en_o}, {31'h0, e.wb_en});
        chk({tag, " R5/R7/R8/R9 wb_data"}, wb_data_o, e.wb_data);
        chk({tag, " R10 wb_reg"}, {28'h0, wb_reg_o}, {28'h0, e.wb_reg});
        chk({tag, " R10 data_reg"}, {28'h0, data_reg_o}, {28'h0, e.data_reg});
        chk({tag, " R12 ld_data"}, ld_data_o, exp_ld);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        chk("R1 vld", {31'h0, xfer_vld_o}, 32'h0);
        chk("R1 addr", xfer_addr_o, 32'h0);
        chk("R1 wb", {27'h0, wb_en_o, xfer_be_o}, 32'h0);
        chk("R1 wb_data", wb_data_o, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", {xfer_vld_o, xfer_byte_o, xfer_load_o, wb_en_o, wb_reg_o, data_reg_o},
            32'h0);
        // R13 reference words
        issue(1'b1, 32'hE56DA004, 32'h0000_1000, 32'h0, 1'b0, "R13 byte-store");
        issue(1'b1, 32'hE59D8000, 32'h0000_2000, 32'h0, 1'b0, "R13 word-load");
        // R4 post-index byte load with shifted register subtract, W=0
        issue(1'b1, 32'hE6512223, 32'h0000_0100, 32'h0000_0050, 1'b0, "R4 post-ldrb");
        // R9 zero-amount shifts: LSL, LSR, ASR, ROR with carry (pre, up, W=1)
        issue(1'b1, 32'hE7A12003, 32'h0000_0010, 32'h8000_0001, 1'b0, "R9 lsl0");
        issue(1'b1, 32'hE7A12023, 32'h0000_0010, 32'h8000_0001, 1'b0, "R9 lsr0");
        issue(1'b1, 32'hE7A12043, 32'h0000_0010, 32'h8000_0001, 1'b0, "R9 asr0");
        issue(1'b1, 32'hE7A12063, 32'h0000_0010, 32'h0000_0003, 1'b1, "R9 ror0");
        // R2 idle cycle with a live-looking word
        issue(1'b0, 32'hE56DA004, 32'h1234_5678, 32'h0, 1'b0, "R2 idle");
        // R7 immediate byte load on every lane
        for (int k = 0; k < 4; k++)
            issue(1'b1, 32'hE5D12000 | k, 32'h0000_4000, 32'h0, 1'b0, "R7 lane");
        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [31:0] ins;
            ins = ($urandom & 32'hF3FF_FFFF) | 32'h0400_0000;
            issue(($urandom % 5) != 0, ins, $urandom, $urandom, 1'($urandom), "R8 rand");
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule